// File: doc/BRIEF.md
# Transceiver Mode and Bus-Wakeup Controller

This block is the digital control core of a high-speed CAN line driver. A standby select input picks one of two operating modes. In normal mode the transmitter, the normal receiver and the common-mode split reference are enabled. The receive-data output follows the sampled bus state: it is low for dominant and high for recessive. In standby mode all three enables are off. A low-power wake detector then watches the sampled bus-dominant bit and drives the receive-data output in place of the normal receiver.

The wake detector has a symmetric filter. The bus level must differ from the current wake state for `WAKE_TICKS` consecutive timebase ticks before that state flips, and this holds in both directions. The wake indication is therefore not latched: a recessive bus clears it after the same filter time. The elaboration parameter `WAKE_ON_HELD` selects how a dominant level already present when standby is entered is treated. When it is 1, that dominant level counts toward a wakeup. When it is 0, the bus must first be seen recessive before a dominant level can count, so a permanently stuck bus cannot keep waking the node. Leaving standby goes through a delay of `MODE_TICKS` ticks. The enables stay off and the receive output stays high during that delay.

Top module: `xcvr_wake_ctrl`

## Requirements
- R1: One clock after `stby_req` is sampled high, the block is in standby and `tx_en`, `rx_en` and `split_en` are all low.
- R2: In normal mode `rx_out` equals the inverse of `bus_dom` in the same cycle (1 = dominant gives 0).
- R3: `tx_en`, `rx_en` and `split_en` are high exactly when the block is in normal mode.
- R4: In standby, `rx_out` goes low after `bus_dom` has been high on `WAKE_TICKS` consecutive ticks. After one tick fewer, it is still high.
- R5: After a wake, `rx_out` returns high only once `bus_dom` has been low on `WAKE_TICKS` consecutive ticks. A shorter recessive gap leaves it low.
- R6: With `WAKE_ON_HELD`=1, a dominant level present at standby entry wakes the node `WAKE_TICKS` ticks after entry.
- R7: With `WAKE_ON_HELD`=0, a dominant level present at standby entry never wakes the node while it persists. Once `bus_dom` has been seen low, a new dominant level of `WAKE_TICKS` ticks wakes it.
- R8: The filter count, the wake state and the arming state are cleared on every entry into standby, so a partial dominant count does not carry across a mode change.
- R9: After `stby_req` falls, the block spends one clock plus `MODE_TICKS` ticks leaving standby. During this time `rx_out` is high and all enables are low.
- R10: After reset the block is in standby with `rx_out` high and all enables low, as if the select input were unconnected.
- R11: Clock cycles without `tick` neither advance nor clear the wake filter while the bus level is steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase strobe for the filter and mode-change counters |
| stby_req | input | 1 | Mode select: 1 = standby, 0 = normal |
| bus_dom | input | 1 | Sampled bus comparator bit: 1 = dominant |
| rx_out | output | 1 | Receive data: low for dominant bus or for a detected wakeup |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Normal receiver enable |
| split_en | output | 1 | Common-mode split reference enable |

## Verification
The mode register updates on the first clock edge after `stby_req` changes. The filter state updates on the edge of the qualifying tick. `rx_out` is a combinational selection from those registers and the present `bus_dom`. Normal-mode echo is therefore due in the same cycle, and mode-change and wake results are due one edge after the deciding sample. The bench changes inputs just after a falling edge, lets one rising edge pass and compares at the next falling edge. Its reference model advances at the same rising edge, so each compare matches the design's update cycle.

// File: rtl/xwk_pkg.sv
package xwk_pkg;
   typedef enum logic [1:0] {
      XM_STBY  = 2'd0,
      XM_LEAVE = 2'd1,
      XM_NORM  = 2'd2
   } xwk_mode_e;
endpackage

// File: rtl/xwk_mode_seq.sv
module xwk_mode_seq
   import xwk_pkg::*;
#(
   parameter int MODE_TICKS = 8
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      stby_req,
   output xwk_mode_e mode
);
   localparam int CW = $clog2(MODE_TICKS + 1) + 1;
   localparam logic [CW-1:0] LAST = CW'(MODE_TICKS - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode  <= XM_STBY;
         cnt_q <= '0;
      end else if (stby_req) begin
         mode  <= XM_STBY;
         cnt_q <= '0;
      end else begin
         unique case (mode)
            XM_STBY: begin
               mode  <= XM_LEAVE;
               cnt_q <= '0;
            end
            XM_LEAVE: begin
               if (tick) begin
                  if (cnt_q == LAST) begin
                     mode  <= XM_NORM;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: mode <= XM_NORM;
         endcase
      end
   end
endmodule

// File: rtl/xwk_wake_filt.sv
module xwk_wake_filt #(
   parameter int WAKE_TICKS   = 500,
   parameter bit WAKE_ON_HELD = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic active,
   input  logic bus_dom,
   output logic wake
);
   localparam int CW = $clog2(WAKE_TICKS + 1) + 1;
   localparam logic [CW-1:0] LAST = CW'(WAKE_TICKS - 1);

   logic          armed;
   logic          level;
   logic [CW-1:0] cnt_q;

   generate
      if (WAKE_ON_HELD) begin : g_uncond
         assign armed = 1'b1;
      end else begin : g_guarded
         logic armed_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       armed_q <= 1'b0;
            else if (!active) armed_q <= 1'b0;
            else if (!bus_dom) armed_q <= 1'b1;
         end
         assign armed = armed_q;
      end
   endgenerate

   assign level = bus_dom & armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake  <= 1'b0;
         cnt_q <= '0;
      end else if (!active) begin
         wake  <= 1'b0;
         cnt_q <= '0;
      end else if (level == wake) begin
         cnt_q <= '0;
      end else if (tick) begin
         if (cnt_q == LAST) begin
            wake  <= ~wake;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/xwk_out_sel.sv
module xwk_out_sel
   import xwk_pkg::*;
(
   input  xwk_mode_e mode,
   input  logic      bus_dom,
   input  logic      wake,
   output logic      rx_out,
   output logic      tx_en,
   output logic      rx_en,
   output logic      split_en
);
   logic norm;
   assign norm     = (mode == XM_NORM);
   assign tx_en    = norm;
   assign rx_en    = norm;
   assign split_en = norm;

   always_comb begin
      unique case (mode)
         XM_NORM:  rx_out = ~bus_dom;
         XM_STBY:  rx_out = ~wake;
         default:  rx_out = 1'b1;
      endcase
   end
endmodule

// File: rtl/xcvr_wake_ctrl.sv
module xcvr_wake_ctrl
   import xwk_pkg::*;
#(
   parameter int WAKE_TICKS   = 500,
   parameter int MODE_TICKS   = 8,
   parameter bit WAKE_ON_HELD = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic stby_req,
   input  logic bus_dom,
   output logic rx_out,
   output logic tx_en,
   output logic rx_en,
   output logic split_en
);
   generate
      if (WAKE_TICKS < 1) begin : g_bad_wake
         $error("WAKE_TICKS must be at least 1");
      end
      if (MODE_TICKS < 1) begin : g_bad_mode
         $error("MODE_TICKS must be at least 1");
      end
   endgenerate

   xwk_mode_e mode;
   logic      wake;

   xwk_mode_seq #(.MODE_TICKS(MODE_TICKS)) u_seq (
      .clk(clk), .rst_n(rst_n), .tick(tick), .stby_req(stby_req), .mode(mode)
   );

   xwk_wake_filt #(.WAKE_TICKS(WAKE_TICKS), .WAKE_ON_HELD(WAKE_ON_HELD)) u_filt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .active(mode == XM_STBY),
      .bus_dom(bus_dom), .wake(wake)
   );

   xwk_out_sel u_sel (
      .mode(mode), .bus_dom(bus_dom), .wake(wake), .rx_out(rx_out),
      .tx_en(tx_en), .rx_en(rx_en), .split_en(split_en)
   );
endmodule

// File: rtl/xcvr_wake_ctrl_chk.sv
module xcvr_wake_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic stby_req,
   input logic bus_dom,
   input logic rx_out,
   input logic tx_en,
   input logic rx_en,
   input logic split_en
);
   p_stby_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stby_req) |-> (!tx_en && !rx_en && !split_en));

   p_norm_echo_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en |-> (rx_out == !bus_dom));

   p_split_tracks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (split_en == tx_en) && (rx_en == tx_en));

   p_wake_needs_dom_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && !$past(tx_en) && $fell(rx_out)) |-> $past(bus_dom));

   p_leave_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && !$past(stby_req)) |-> rx_out);
endmodule

bind xcvr_wake_ctrl xcvr_wake_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .stby_req(stby_req), .bus_dom(bus_dom),
   .rx_out(rx_out), .tx_en(tx_en), .rx_en(rx_en), .split_en(split_en)
);

// File: tb/xcvr_wake_ctrl_bench.sv
module xcvr_wake_ctrl_bench;
   localparam int W = 4;
   localparam int M = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b1;
   logic stby_req = 1'b1;
   logic bus_dom = 1'b0;
   logic [1:0] rx, tx, re, sp;
   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   xcvr_wake_ctrl #(.WAKE_TICKS(W), .MODE_TICKS(M), .WAKE_ON_HELD(1'b0)) u_xcvr_wake_ctrl (
      .clk(clk), .rst_n(rst_n), .tick(tick), .stby_req(stby_req), .bus_dom(bus_dom),
      .rx_out(rx[0]), .tx_en(tx[0]), .rx_en(re[0]), .split_en(sp[0]));

   xcvr_wake_ctrl #(.WAKE_TICKS(W), .MODE_TICKS(M), .WAKE_ON_HELD(1'b1)) u_xcvr_wake_ctrl_unc (
      .clk(clk), .rst_n(rst_n), .tick(tick), .stby_req(stby_req), .bus_dom(bus_dom),
      .rx_out(rx[1]), .tx_en(tx[1]), .rx_en(re[1]), .split_en(sp[1]));

   // reference model: md 0 standby, 1 leaving, 2 normal
   int md, mcnt;
   int wk [2];
   int wcnt [2];
   int arm [2];

   always @(posedge clk) begin
      if (!rst_n) begin
         md = 0; mcnt = 0;
         for (int v = 0; v < 2; v++) begin wk[v] = 0; wcnt[v] = 0; arm[v] = 0; end
      end else begin
         int old;
         old = md;
         for (int v = 0; v < 2; v++) begin
            if (old != 0) begin
               wk[v] = 0; wcnt[v] = 0; arm[v] = 0;
            end else begin
               int lvl;
               lvl = (bus_dom && (v == 1 || arm[v] != 0)) ? 1 : 0;
               if (lvl == wk[v]) wcnt[v] = 0;
               else if (tick) begin
                  wcnt[v]++;
                  if (wcnt[v] == W) begin wk[v] = 1 - wk[v]; wcnt[v] = 0; end
               end
               if (!bus_dom) arm[v] = 1;
            end
         end
         if (stby_req) begin md = 0; mcnt = 0; end
         else if (md == 0) begin md = 1; mcnt = 0; end
         else if (md == 1 && tick) begin
            mcnt++;
            if (mcnt == M) begin md = 2; mcnt = 0; end
         end
      end
   end

   function automatic logic exp_rx(int v);
      if (md == 2) return !bus_dom;
      if (md == 1) return 1'b1;
      return wk[v] == 0;
   endfunction

   task automatic chk(string tag, logic act, logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cmp_model(string tag);
      for (int v = 0; v < 2; v++) begin
         chk(tag, rx[v], exp_rx(v));
         chk({tag, " R3"}, tx[v], md == 2);
         chk({tag, " R3"}, re[v], md == 2);
         chk({tag, " R3"}, sp[v], md == 2);
      end
   endtask

   task automatic step(logic s, logic b, logic t, string tag);
      stby_req = s; bus_dom = b; tick = t;
      @(posedge clk);
      @(negedge clk);
      cmp_model(tag);
   endtask

   initial begin
      #2000000;
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 rx", rx[0], 1'b1); chk("R10 en", tx[0], 1'b0); chk("R10 split", sp[1], 1'b0);
      rst_n = 1'b1;
      step(1, 0, 1, "R10"); step(1, 0, 1, "R10");
      // R4 exact filter length
      for (int i = 0; i < W - 1; i++) step(1, 1, 1, "R4");
      chk("R4 short", rx[0], 1'b1); chk("R4 short", rx[1], 1'b1);
      step(1, 1, 1, "R4");
      chk("R4 wake", rx[0], 1'b0); chk("R4 wake", rx[1], 1'b0);
      // R5 short gap then full release
      step(1, 0, 1, "R5"); step(1, 0, 1, "R5"); step(1, 1, 1, "R5");
      chk("R5 gap", rx[0], 1'b0);
      for (int i = 0; i < W - 1; i++) step(1, 0, 1, "R5");
      chk("R5 hold", rx[1], 1'b0);
      step(1, 0, 1, "R5");
      chk("R5 release", rx[0], 1'b1); chk("R5 release", rx[1], 1'b1);
      // R11 no tick, no progress
      for (int i = 0; i < 10; i++) step(1, 1, 0, "R11");
      chk("R11 idle", rx[0], 1'b1);
      for (int i = 0; i < W; i++) step(1, 1, 1, "R11");
      chk("R11 ticks", rx[0], 1'b0);
      for (int i = 0; i < W; i++) step(1, 0, 1, "R11");
      // R9 leaving standby with dominant bus
      for (int i = 0; i < M; i++) begin
         step(0, 1, 1, "R9");
         chk("R9 leave rx", rx[0], 1'b1); chk("R9 leave en", tx[0], 1'b0);
      end
      step(0, 1, 1, "R9");
      chk("R3 norm en", split_en_any(), 1'b1); chk("R2 dom", rx[0], 1'b0);
      step(0, 0, 1, "R2");
      chk("R2 rec", rx[1], 1'b1);
      // R6 R7 entry with dominant held
      step(0, 1, 1, "R2");
      step(1, 1, 1, "R1");
      chk("R1 off", tx[0], 1'b0); chk("R1 off", sp[1], 1'b0);
      for (int i = 0; i < W - 1; i++) step(1, 1, 1, "R6");
      chk("R6 not yet", rx[1], 1'b1);
      step(1, 1, 1, "R6");
      chk("R6 wake", rx[1], 1'b0);
      for (int i = 0; i < 6; i++) step(1, 1, 1, "R7");
      chk("R7 ignored", rx[0], 1'b1);
      for (int i = 0; i < W + 1; i++) step(1, 0, 1, "R7");
      for (int i = 0; i < W; i++) step(1, 1, 1, "R7");
      chk("R7 rearmed", rx[0], 1'b0);
      // R8 partial count cleared by re-entry
      for (int i = 0; i < W; i++) step(1, 0, 1, "R8");
      step(1, 1, 1, "R8"); step(1, 1, 1, "R8");
      step(0, 1, 1, "R8");
      step(1, 1, 1, "R8");
      for (int i = 0; i < W - 1; i++) step(1, 1, 1, "R8");
      chk("R8 restart", rx[1], 1'b1);
      step(1, 1, 1, "R8");
      chk("R8 full", rx[1], 1'b0); chk("R8 disarmed", rx[0], 1'b1);
      // random phase
      begin
         logic s, b;
         void'($urandom(32'd1234));
         s = 1'b1; b = 1'b0;
         for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(39) == 0) s = ~s;
            if ($urandom_range(5) == 0) b = ~b;
            step(s, b, $urandom_range(3) != 0, "R2 R4 R5 R6 R7 R9 rand");
         end
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   function automatic logic split_en_any();
      return sp[0] & sp[1] & tx[1] & re[0];
   endfunction
endmodule